// File: doc/BRIEF.md
# Memory Test Address Generator

This block supplies the command addresses for a memory traffic test. A mode code, captured on a load strobe, chooses one of three address sources. The first source repeats a constant taken from an input bus. The second is a 32-bit pseudo-random sequence from a linear feedback shift register. The third is a counter that advances by the width of the user data bus, measured in bytes. Each request on a single-cycle strobe produces one new address. The address appears one cycle later, together with a valid pulse.

The block also reports when the constant-address source is active. A companion data generator uses that flag to fall back to constant data and to stop producing pseudo-random data. Every address the block emits is aligned to the data bus width, so the low bits that address bytes inside one bus word are always zero.

Top module: `mtg_addr_gen`

## Requirements
- R1: After a synchronous reset, `addr_o` is 0, `valid_o` is 0 and `fixed_mode_o` is 0. The active source is pseudo-random, the LFSR holds `DEF_SEED`, and the counter holds 0.
- R2: A request (`req_i`=1 with `load_i`=0) at a clock edge makes `valid_o` equal 1 for exactly the following cycle and updates `addr_o` at that edge. In a cycle without a request, `valid_o` is 0 and `addr_o` keeps its value.
- R3: Mode code 3'd1 selects the constant source. Each request outputs the value of `fixed_addr_i` at the request edge, aligned. `fixed_mode_o` is 1 while this source is active and 0 under any other source.
- R4: Mode code 3'd2 selects the pseudo-random source. A request outputs the LFSR state, aligned, and then steps the state to `(s >> 1) ^ (s[0] ? 32'h80200003 : 0)`.
- R5: Mode code 3'd3 selects the counter source. A request outputs the counter and then adds `DATA_W/8` to it, wrapping modulo 2^32.
- R6: A load (`load_i`=1) does four things. It captures `mode_i` as the active source. It loads the counter with `fixed_addr_i` aligned. It loads the LFSR with `seed_i`, or with `DEF_SEED` when `seed_i` is 0. A request in the same cycle is ignored: no valid pulse follows and no state steps.
- R7: Mode codes 3'd0 and 3'd4 through 3'd7 behave exactly like 3'd2 and leave `fixed_mode_o` at 0.
- R8: The low log2(`DATA_W`/8) bits of every emitted address are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Source code, captured on load |
| fixed_addr_i | input | ADDR_W | Constant address; counter start value on load |
| seed_i | input | ADDR_W | LFSR seed, taken on load |
| load_i | input | 1 | Capture mode and reload counter and LFSR |
| req_i | input | 1 | Request the next address |
| addr_o | output | ADDR_W | Current address (registered) |
| valid_o | output | 1 | One-cycle pulse after each accepted request |
| fixed_mode_o | output | 1 | Constant source is active |

## Verification
The bench builds the block with `DATA_W`=64, which gives a step of 8 bytes and a 3-bit alignment field. A counter start of 32'hFFFFFFF0 then wraps through zero within three requests. It also builds the block with the default seed, so that an all-zero seed and the free-running state after reset can both be compared against the same known start value. With an unaligned constant address and an odd seed, the alignment clearing becomes visible in every source.

// File: rtl/mtg_pkg.sv
package mtg_pkg;

  localparam logic [2:0] MODE_FIXED = 3'd1;
  localparam logic [2:0] MODE_PRBS  = 3'd2;
  localparam logic [2:0] MODE_SEQ   = 3'd3;

  typedef enum logic [1:0] {
    SRC_FIXED = 2'd0,
    SRC_PRBS  = 2'd1,
    SRC_SEQ   = 2'd2
  } src_e;

  // Codes without a source of their own fall back to pseudo-random.
  function automatic src_e decode_mode(input logic [2:0] code);
    case (code)
      MODE_FIXED: decode_mode = SRC_FIXED;
      MODE_SEQ:   decode_mode = SRC_SEQ;
      default:    decode_mode = SRC_PRBS;
    endcase
  endfunction

endpackage

// File: rtl/mtg_mode_ctl.sv
module mtg_mode_ctl
  import mtg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load_i,
  input  logic [2:0] mode_i,
  output src_e       sel_o,
  output logic       fixed_o
);

  src_e sel_q;
  logic fixed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= SRC_PRBS;
      fixed_q <= 1'b0;
    end else if (load_i) begin
      sel_q   <= decode_mode(mode_i);
      fixed_q <= (mode_i == MODE_FIXED);
    end
  end

  assign sel_o   = sel_q;
  assign fixed_o = fixed_q;

  AST_FIXED_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    (load_i && mode_i == 3'd1) |=> fixed_o); // R3
  AST_ODD_CODE_PRBS: assert property (@(posedge clk) disable iff (rst)
    (load_i && mode_i != 3'd1 && mode_i != 3'd3) |=> (sel_o == SRC_PRBS && !fixed_o)); // R7

endmodule

// File: rtl/mtg_lfsr.sv
module mtg_lfsr #(
  parameter int              W        = 32,
  parameter logic [W-1:0]    TAP_MASK = 32'h8020_0003,
  parameter logic [W-1:0]    DEF_SEED = 32'h1D87_2B41
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic         step_i,
  output logic [W-1:0] state_o
);

  logic [W-1:0] state_q;
  logic [W-1:0] state_nx;
  logic [W-1:0] seed_safe;

  assign seed_safe = (seed_i == '0) ? DEF_SEED : seed_i;
  assign state_nx  = (state_q >> 1) ^ (state_q[0] ? TAP_MASK : '0);

  always_ff @(posedge clk) begin
    if (rst)         state_q <= DEF_SEED;
    else if (load_i) state_q <= seed_safe;
    else if (step_i) state_q <= state_nx;
  end

  assign state_o = state_q;

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
    state_o != '0); // R4
  AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !step_i) |=> $stable(state_o)); // R4

endmodule

// File: rtl/mtg_seq_ctr.sv
module mtg_seq_ctr #(
  parameter int W    = 32,
  parameter int STEP = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] INC = W'(STEP);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (step_i) cnt_q <= cnt_q + INC;
  end

  assign cnt_o = cnt_q;

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (step_i && !load_i) |=> (cnt_o == $past(cnt_o) + INC)); // R5
  AST_SEQ_LOAD: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt_o == $past(load_val_i))); // R6

endmodule

// File: rtl/mtg_addr_gen.sv
module mtg_addr_gen
  import mtg_pkg::*;
#(
  parameter int                 ADDR_W   = 32,
  parameter int                 DATA_W   = 256,
  parameter logic [ADDR_W-1:0]  TAP_MASK = 32'h8020_0003,
  parameter logic [ADDR_W-1:0]  DEF_SEED = 32'h1D87_2B41
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        mode_i,
  input  logic [ADDR_W-1:0] fixed_addr_i,
  input  logic [ADDR_W-1:0] seed_i,
  input  logic              load_i,
  input  logic              req_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o,
  output logic              fixed_mode_o
);

  localparam int                STEP_B     = DATA_W / 8;
  localparam int                ALIGN      = $clog2(STEP_B);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = {ADDR_W{1'b1}} << ALIGN;

  src_e              sel;
  logic              take;
  logic [ADDR_W-1:0] lfsr_state;
  logic [ADDR_W-1:0] ctr_val;
  logic [ADDR_W-1:0] src_addr;
  logic [ADDR_W-1:0] addr_q;
  logic              valid_q;

  assign take = req_i && !load_i;

  mtg_mode_ctl u_mode (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load_i),
    .mode_i  (mode_i),
    .sel_o   (sel),
    .fixed_o (fixed_mode_o)
  );

  mtg_lfsr #(
    .W        (ADDR_W),
    .TAP_MASK (TAP_MASK),
    .DEF_SEED (DEF_SEED)
  ) u_lfsr (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load_i),
    .seed_i  (seed_i),
    .step_i  (take && sel == SRC_PRBS),
    .state_o (lfsr_state)
  );

  mtg_seq_ctr #(
    .W    (ADDR_W),
    .STEP (STEP_B)
  ) u_ctr (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load_i),
    .load_val_i (fixed_addr_i & ALIGN_MASK),
    .step_i     (take && sel == SRC_SEQ),
    .cnt_o      (ctr_val)
  );

  always_comb begin
    case (sel)
      SRC_FIXED: src_addr = fixed_addr_i;
      SRC_SEQ:   src_addr = ctr_val;
      default:   src_addr = lfsr_state;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= take;
      if (take) addr_q <= src_addr & ALIGN_MASK;
    end
  end

  assign addr_o  = addr_q;
  assign valid_o = valid_q;

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    (req_i && !load_i) |=> valid_o); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(req_i && !load_i) |=> (!valid_o && $stable(addr_o))); // R2
  AST_LOAD_BLOCKS_REQ: assert property (@(posedge clk) disable iff (rst)
    load_i |=> !valid_o); // R6

  generate
    if (ALIGN > 0) begin : g_align_chk
      AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        addr_o[ALIGN-1:0] == '0); // R8
    end
  endgenerate

  initial begin
    AST_WIDTH_OK: assert (DATA_W >= 8 && ADDR_W >= 8); // R8
  end

endmodule

// File: tb/mtg_addr_gen_tb.sv
module mtg_addr_gen_tb_top;

  localparam int          AW    = 32;
  localparam int          DW    = 64;
  localparam int          STEPB = DW / 8;
  localparam logic [31:0] MASK  = 32'hFFFF_FFF8;
  localparam logic [31:0] TAPS  = 32'h8020_0003;
  localparam logic [31:0] DEFS  = 32'h1D87_2B41;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    mode_i = 3'd0;
  logic [AW-1:0] fixed_addr_i = '0;
  logic [AW-1:0] seed_i = '0;
  logic          load_i = 1'b0;
  logic          req_i = 1'b0;
  logic [AW-1:0] addr_o;
  logic          valid_o;
  logic          fixed_mode_o;

  always #4 clk = ~clk;

  mtg_addr_gen #(
    .ADDR_W   (AW),
    .DATA_W   (DW),
    .TAP_MASK (TAPS),
    .DEF_SEED (DEFS)
  ) dut_i (
    .clk          (clk),
    .rst          (rst),
    .mode_i       (mode_i),
    .fixed_addr_i (fixed_addr_i),
    .seed_i       (seed_i),
    .load_i       (load_i),
    .req_i        (req_i),
    .addr_o       (addr_o),
    .valid_o      (valid_o),
    .fixed_mode_o (fixed_mode_o)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [31:0] addr;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  // Independent model state
  int          m_src = 1;   // 0 fixed, 1 prbs, 2 seq
  logic [31:0] m_lfsr = DEFS;
  logic [31:0] m_ctr = '0;
  logic [31:0] last_addr = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lfsr_next(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? TAPS : 32'h0);
  endfunction

  // Driver: one request, expected address pushed into the scoreboard
  task automatic do_req(input logic [31:0] fx, input string tag);
    exp_t e;
    @(negedge clk);
    load_i = 1'b0;
    req_i = 1'b1;
    fixed_addr_i = fx;
    case (m_src)
      0: e.addr = fx & MASK;
      2: begin e.addr = m_ctr; m_ctr = m_ctr + STEPB; end
      default: begin e.addr = m_lfsr & MASK; m_lfsr = lfsr_next(m_lfsr); end
    endcase
    e.tag = tag;
    last_addr = e.addr;
    exp_q.push_back(e);
  endtask

  task automatic do_load(input logic [2:0] md, input logic [31:0] fx, input logic [31:0] sd,
                         input bit with_req);
    @(negedge clk);
    load_i = 1'b1;
    req_i = with_req;
    mode_i = md;
    fixed_addr_i = fx;
    seed_i = sd;
    m_src = (md == 3'd1) ? 0 : (md == 3'd3) ? 2 : 1;
    m_ctr = fx & MASK;
    m_lfsr = (sd == 32'h0) ? DEFS : sd;
    @(negedge clk);
    load_i = 1'b0;
    req_i = 1'b0;
    chk(fixed_mode_o == (md == 3'd1), (md == 3'd1) ? "R3 fixed flag" : "R7 fixed flag low",
        {31'h0, fixed_mode_o}, {31'h0, md == 3'd1});
  endtask

  task automatic do_idle(input string tag);
    @(negedge clk);
    req_i = 1'b0;
    load_i = 1'b0;
    @(negedge clk);
    chk(valid_o == 1'b0, tag, {31'h0, valid_o}, 32'h0);
    chk(addr_o == last_addr, tag, addr_o, last_addr);
  endtask

  // Monitor: pop and compare on each valid pulse
  always @(negedge clk) begin
    if (!rst && valid_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected valid", addr_o, 32'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(addr_o == e.addr, e.tag, addr_o, e.addr);
        chk(addr_o[2:0] == 3'b000, "R8 alignment", {29'h0, addr_o[2:0]}, 32'h0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(addr_o == 32'h0, "R1 reset addr", addr_o, 32'h0);
    chk(valid_o == 1'b0, "R1 reset valid", {31'h0, valid_o}, 32'h0);
    chk(fixed_mode_o == 1'b0, "R1 reset fixed flag", {31'h0, fixed_mode_o}, 32'h0);

    // R1/R4: default source after reset is pseudo-random from DEF_SEED
    for (int i = 0; i < 4; i++) do_req(32'h0, "R1 R4 default prbs");
    do_idle("R2 hold after prbs");

    // R5: counter source with unaligned start
    do_load(3'd3, 32'h1000_0013, 32'h0, 1'b0);
    for (int i = 0; i < 4; i++) do_req(32'h0, "R5 seq step");
    do_idle("R2 hold after seq");

    // R5: wrap modulo 2^32
    do_load(3'd3, 32'hFFFF_FFF0, 32'h0, 1'b0);
    for (int i = 0; i < 3; i++) do_req(32'h0, "R5 seq wrap");

    // R3: constant source follows the input at each request
    do_load(3'd1, 32'h0000_ABCF, 32'h0, 1'b0);
    do_req(32'h0000_ABCF, "R3 fixed addr");
    do_req(32'h0000_ABCF, "R3 fixed addr repeat");
    do_req(32'h7654_3217, "R3 fixed addr change");
    do_idle("R2 hold after fixed");

    // R6: zero seed replaced by DEF_SEED
    do_load(3'd2, 32'h0, 32'h0, 1'b0);
    for (int i = 0; i < 3; i++) do_req(32'h0, "R6 zero seed prbs");

    // R4/R2: explicit seed with idle gaps between requests
    do_load(3'd2, 32'h0, 32'h1234_5679, 1'b0);
    do_req(32'h0, "R4 seeded prbs");
    do_idle("R2 idle gap");
    do_req(32'h0, "R4 seeded prbs after gap");
    do_req(32'h0, "R4 seeded prbs");

    // R7: unsupported codes behave as pseudo-random
    do_load(3'd5, 32'h0, 32'hCAFE_F00D, 1'b0);
    for (int i = 0; i < 3; i++) do_req(32'h0, "R7 code5 prbs");
    do_load(3'd0, 32'h0, 32'h0BAD_BEEF, 1'b0);
    do_req(32'h0, "R7 code0 prbs");

    // R6: request with load is ignored
    do_idle("R2 settle");
    do_load(3'd3, 32'h0000_4000, 32'h0, 1'b1);
    chk(valid_o == 1'b0, "R6 load wins over req", {31'h0, valid_o}, 32'h0);
    do_req(32'h0, "R6 counter not stepped by ignored req");
    do_req(32'h0, "R5 seq after load");

    @(negedge clk);
    req_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all requests answered", exp_q.size(), 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule